// File: doc/BRIEF.md
# Multi-dimensional vector index remapper

This block turns a linear walk over the elements of a vector into a reordered element index, so that matrix data held in a flat register range can be read or written transposed, strided, mirrored or rotated in place. The shape is a nest of three counters, one per dimension (x, y, z). The order in which they carry into each other is programmable. The walk can be pre-advanced by an offset, any dimension can be mirrored, and low dimensions can be masked out before the linear index is formed.

Four shape words are held in slots loaded through a configuration port. A start pulse picks one slot, copies its shape into the walker and pre-advances the counters by the offset, one step per cycle. During that time `busy` is high. Afterwards `idx_valid` rises with the first index. Each `step` pulse moves to the next element. `row_end` marks the element that closes an inner row.

Shape word layout (32 bits at default parameters): bits [5:0] x limit minus one, [11:6] y limit minus one, [17:12] z limit minus one, [22:18] offset, [24:23] first dimension in the carry order, [26:25] second dimension in the carry order, [29:27] invert flags (bit 27 for x, 28 for y, 29 for z), [31:30] apply threshold. Dimension numbers are 0 for x, 1 for y and 2 for z.

Top module: `vidx_remap`

## Requirements
- R1: After reset `busy`, `idx_valid` and `cfg_err` are 0, `idx` is 0 and `row_end` is 0.
- R2: A write with `cfg_we` stores `cfg_data` into slot `cfg_slot`. A `start` uses only the slot named by `start_slot`, and writes to other slots do not change it.
- R3: `busy` is high in the cycles after a start edge until `idx_valid` rises. `idx_valid` rises exactly offset+1 cycles after the start edge, and the two are never high together.
- R4: A step advances the dimension named first in the order. When that dimension is at its limit minus one, it wraps to 0 and carries into the second named dimension, and from there into the remaining one.
- R5: Before the first valid index, the counters are advanced offset times by the carry rule of R4, starting from all zero.
- R6: `idx` = ix0 + ix1*X + ix2*X*Y, where X and Y are the x and y limits and ixN is the modified counter of dimension N.
- R7: When the invert flag of dimension N is set, ixN is limitN-1-counterN.
- R8: A dimension whose number is below the apply threshold contributes 0 to `idx`.
- R9: `row_end` is 1 on every element whose emitted position since start, counted from 0, is k*L-1, where L is the limit of the first-ordered dimension.
- R10: After X*Y*Z steps the walk returns to the starting element and repeats the same sequence.
- R11: If the first and second order fields are equal or either one is 3, `cfg_err` is 1 until the next start and the walk uses the order x, y, z. A valid order clears `cfg_err` at start.
- R12: `step` has no effect while `idx_valid` is 0. With `idx_valid` high and no step, `idx` and `row_end` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write a shape word into a slot |
| cfg_slot | input | 2 | Slot written |
| cfg_data | input | 32 | Shape word |
| start | input | 1 | Begin a walk with the selected slot |
| start_slot | input | 2 | Slot used by start |
| step | input | 1 | Advance to the next element |
| busy | output | 1 | Offset pre-advance in progress |
| idx_valid | output | 1 | `idx` and `row_end` are meaningful |
| idx | output | 18 | Remapped element index |
| row_end | output | 1 | Current element closes an inner row |
| cfg_err | output | 1 | Order field of the started shape was not a permutation |

## Verification
The bench uses the default parameters: 6-bit limit fields, a 5-bit offset and four slots. Shapes up to 4x4x4 then fit with room to spare, so every order permutation, offsets 0 to 5, all invert combinations and all apply thresholds can be compared element by element against a model in the bench. Offsets above a full pass and runs longer than one pass also come within reach, which checks the wrap behaviour of the carry chain.

// File: rtl/vidx_remap.sv
module vidx_remap #(
  parameter int LIM_W = 6,
  parameter int OFF_W = 5,
  parameter int NSLOT = 4,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int IDX_W = 3 * LIM_W,
  localparam int CFG_W = 3 * LIM_W + OFF_W + 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              start,
  input  logic [SLOT_W-1:0] start_slot,
  input  logic              step,
  output logic              busy,
  output logic              idx_valid,
  output logic [IDX_W-1:0]  idx,
  output logic              row_end,
  output logic              cfg_err
);
  localparam int P_OFF = 3 * LIM_W;
  localparam int P_ORD = P_OFF + OFF_W;
  localparam int P_INV = P_ORD + 4;
  localparam int P_APP = P_INV + 3;

  logic [CFG_W-1:0] slots [NSLOT];
  logic [LIM_W-1:0] lm1 [3];
  logic [LIM_W-1:0] cnt [3];
  logic [LIM_W-1:0] nxt [3];
  logic [1:0]       ord [3];
  logic [2:0]       inv;
  logic [1:0]       app;
  logic [OFF_W-1:0] offc;
  logic [LIM_W-1:0] rc;

  logic [CFG_W-1:0] sel;
  logic [1:0]       o0, o1;
  logic             ord_ok;
  assign sel    = slots[start_slot];
  assign o0     = sel[P_ORD +: 2];
  assign o1     = sel[P_ORD+2 +: 2];
  assign ord_ok = (o0 != 2'd3) && (o1 != 2'd3) && (o0 != o1);

  always_comb begin
    logic carry;
    carry = 1'b1;
    for (int i = 0; i < 3; i++) nxt[i] = cnt[i];
    for (int k = 0; k < 3; k++) begin
      if (carry) begin
        if (cnt[ord[k]] == lm1[ord[k]]) nxt[ord[k]] = '0;
        else begin
          nxt[ord[k]] = cnt[ord[k]] + 1'b1;
          carry = 1'b0;
        end
      end
    end
  end

  always_comb begin
    logic [IDX_W-1:0] ix [3];
    logic [IDX_W-1:0] xs, ys;
    for (int n = 0; n < 3; n++) begin
      if (n < int'(app)) ix[n] = '0;
      else if (inv[n]) ix[n] = IDX_W'(lm1[n] - cnt[n]);
      else ix[n] = IDX_W'(cnt[n]);
    end
    xs = IDX_W'(lm1[0]) + 1'b1;
    ys = IDX_W'(lm1[1]) + 1'b1;
    idx = ix[0] + ix[1] * xs + ix[2] * xs * ys;
  end

  assign row_end = idx_valid && (rc == lm1[ord[0]]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) slots[s] <= '0;
    end else if (cfg_we) begin
      slots[cfg_slot] <= cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        lm1[i] <= '0;
        cnt[i] <= '0;
        ord[i] <= 2'(i);
      end
      inv       <= '0;
      app       <= '0;
      offc      <= '0;
      rc        <= '0;
      busy      <= 1'b0;
      idx_valid <= 1'b0;
      cfg_err   <= 1'b0;
    end else if (start) begin
      for (int i = 0; i < 3; i++) begin
        lm1[i] <= sel[i*LIM_W +: LIM_W];
        cnt[i] <= '0;
      end
      ord[0]    <= ord_ok ? o0 : 2'd0;
      ord[1]    <= ord_ok ? o1 : 2'd1;
      ord[2]    <= ord_ok ? 2'd3 - o0 - o1 : 2'd2;
      inv       <= sel[P_INV +: 3];
      app       <= sel[P_APP +: 2];
      offc      <= sel[P_OFF +: OFF_W];
      rc        <= '0;
      busy      <= 1'b1;
      idx_valid <= 1'b0;
      cfg_err   <= !ord_ok;
    end else if (busy) begin
      if (offc != '0) begin
        for (int i = 0; i < 3; i++) cnt[i] <= nxt[i];
        offc <= offc - 1'b1;
      end else begin
        busy      <= 1'b0;
        idx_valid <= 1'b1;
      end
    end else if (idx_valid && step) begin
      for (int i = 0; i < 3; i++) cnt[i] <= nxt[i];
      rc <= row_end ? '0 : rc + 1'b1;
    end
  end
endmodule

module vidx_remap_chk #(
  parameter int IDX_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             step,
  input logic             busy,
  input logic             idx_valid,
  input logic [IDX_W-1:0] idx,
  input logic             row_end,
  input logic             cfg_err
);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !idx_valid);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && idx_valid));
  p_busy_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> idx_valid);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && !step && !start |=> idx_valid && $stable(idx) && $stable(row_end));
  p_err_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cfg_err));
  p_row_end_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |-> idx_valid);
endmodule

bind vidx_remap vidx_remap_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step(step), .busy(busy),
  .idx_valid(idx_valid), .idx(idx), .row_end(row_end), .cfg_err(cfg_err)
);

// File: tb/vidx_remap_bench.sv
module vidx_remap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic [31:0] cfg_data = '0;
  logic        start = 1'b0;
  logic [1:0]  start_slot = '0;
  logic        step = 1'b0;
  logic        busy, idx_valid, row_end, cfg_err;
  logic [17:0] idx;

  int n_run = 0;
  int n_fail = 0;

  vidx_remap u_vidx_remap (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_data(cfg_data), .start(start), .start_slot(start_slot),
    .step(step), .busy(busy), .idx_valid(idx_valid), .idx(idx),
    .row_end(row_end), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  int m_lim [3];
  int m_c [3];
  int m_ord [3];
  int m_inv, m_app, m_rc, m_off;
  bit m_bad;

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int x, int y, int z, int off, int o0, int o1, int inv, int app);
    logic [31:0] w;
    w = '0;
    w[5:0] = 6'(x - 1);
    w[11:6] = 6'(y - 1);
    w[17:12] = 6'(z - 1);
    w[22:18] = 5'(off);
    w[24:23] = 2'(o0);
    w[26:25] = 2'(o1);
    w[29:27] = 3'(inv);
    w[31:30] = 2'(app);
    return w;
  endfunction

  task automatic m_adv();
    bit carry;
    carry = 1'b1;
    for (int k = 0; k < 3; k++) begin
      if (carry) begin
        m_c[m_ord[k]]++;
        if (m_c[m_ord[k]] == m_lim[m_ord[k]]) m_c[m_ord[k]] = 0;
        else carry = 1'b0;
      end
    end
  endtask

  function automatic int m_idx();
    int ix [3];
    for (int n = 0; n < 3; n++) begin
      ix[n] = m_c[n];
      if (m_inv[n]) ix[n] = m_lim[n] - 1 - m_c[n];
      if (n < m_app) ix[n] = 0;
    end
    return ix[0] + ix[1] * m_lim[0] + ix[2] * m_lim[0] * m_lim[1];
  endfunction

  task automatic load(int slot, logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 2'(slot); cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic m_setup(logic [31:0] w);
    int o0, o1;
    m_lim[0] = int'(w[5:0]) + 1;
    m_lim[1] = int'(w[11:6]) + 1;
    m_lim[2] = int'(w[17:12]) + 1;
    m_off = int'(w[22:18]);
    o0 = int'(w[24:23]);
    o1 = int'(w[26:25]);
    m_inv = int'(w[29:27]);
    m_app = int'(w[31:30]);
    m_bad = (o0 == 3) || (o1 == 3) || (o0 == o1);
    if (m_bad) begin
      m_ord[0] = 0; m_ord[1] = 1; m_ord[2] = 2;
    end else begin
      m_ord[0] = o0; m_ord[1] = o1; m_ord[2] = 3 - o0 - o1;
    end
    for (int i = 0; i < 3; i++) m_c[i] = 0;
    m_rc = 0;
    for (int i = 0; i < m_off; i++) m_adv();
  endtask

  // start slot, wait for valid, then compare nsteps+1 elements
  task automatic run(string req, int slot, logic [31:0] w, int nsteps, bit poke);
    int n;
    m_setup(w);
    @(negedge clk);
    start = 1'b1; start_slot = 2'(slot);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!idx_valid && n < 100) begin
      chk("R3", "busy during pre-advance", int'(busy), 1);
      n++;
      step = poke;
      @(negedge clk);
      step = 1'b0;
    end
    chk("R3", "cycles to valid", n, m_off + 1);
    chk("R3", "busy after valid", int'(busy), 0);
    chk("R11", "cfg_err", int'(cfg_err), int'(m_bad));
    for (int s = 0; s <= nsteps; s++) begin
      chk(req, $sformatf("idx at element %0d", s), int'(idx), m_idx());
      chk("R9", $sformatf("row_end at element %0d", s), int'(row_end),
          int'(m_rc == m_lim[m_ord[0]] - 1));
      if (s != nsteps) begin
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        m_adv();
        m_rc = (m_rc == m_lim[m_ord[0]] - 1) ? 0 : m_rc + 1;
      end
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "idx_valid", int'(idx_valid), 0);
    chk("R1", "idx", int'(idx), 0);
    chk("R1", "row_end", int'(row_end), 0);
    chk("R1", "cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_basic();
    logic [31:0] w;
    w = mk(3, 4, 1, 0, 0, 1, 0, 0);
    load(0, w);
    run("R6", 0, w, 11, 1'b0);
  endtask

  task automatic t_perms();
    int p0 [6] = '{0, 0, 1, 1, 2, 2};
    int p1 [6] = '{1, 2, 0, 2, 0, 1};
    for (int p = 0; p < 6; p++)
      for (int off = 0; off < 4; off++) begin
        logic [31:0] w;
        w = mk(4, 3, 2, off, p0[p], p1[p], 0, 0);
        load(1, w);
        run(off == 0 ? "R4" : "R5", 1, w, 23, 1'b0);
      end
  endtask

  task automatic t_invert();
    for (int v = 0; v < 8; v++) begin
      logic [31:0] w;
      w = mk(4, 4, 4, 1, 2, 0, v, 0);
      load(2, w);
      run("R7", 2, w, 63, 1'b0);
    end
  endtask

  task automatic t_apply();
    for (int a = 0; a < 4; a++) begin
      logic [31:0] w;
      w = mk(3, 2, 4, 2, 1, 2, a == 3 ? 7 : 0, a);
      load(3, w);
      run("R8", 3, w, 23, 1'b0);
    end
  endtask

  task automatic t_wrap();
    logic [31:0] w;
    int first;
    w = mk(2, 3, 2, 3, 2, 1, 0, 0);
    load(0, w);
    run("R10", 0, w, 12, 1'b0);
    m_setup(w);
    first = m_idx();
    chk("R10", "index after full pass", int'(idx), first);
    w = mk(2, 2, 2, 9, 0, 1, 0, 0);
    load(0, w);
    run("R10", 0, w, 16, 1'b0);
  endtask

  task automatic t_bad();
    logic [31:0] w;
    w = mk(3, 2, 2, 0, 1, 1, 0, 0);
    load(1, w);
    run("R11", 1, w, 11, 1'b0);
    w = mk(2, 3, 2, 1, 3, 0, 0, 0);
    load(1, w);
    run("R11", 1, w, 11, 1'b0);
    w = mk(2, 3, 2, 0, 2, 0, 0, 0);
    load(1, w);
    run("R11", 1, w, 3, 1'b0);
  endtask

  task automatic t_ignore();
    logic [31:0] w;
    logic [17:0] held;
    w = mk(4, 4, 2, 5, 1, 0, 0, 0);
    load(2, w);
    run("R12", 2, w, 3, 1'b1);
    held = idx;
    repeat (3) @(negedge clk);
    chk("R12", "idx held without step", int'(idx), int'(held));
  endtask

  task automatic t_slots();
    logic [31:0] w [4];
    for (int s = 0; s < 4; s++) begin
      w[s] = mk(2 + s, 3, 2, s, (s + 1) % 3, (s + 2) % 3, s, 0);
      load(s, w[s]);
    end
    run("R2", 2, w[2], 10, 1'b0);
    load(3, mk(4, 4, 4, 0, 2, 1, 5, 1));
    run("R2", 1, w[1], 10, 1'b0);
    run("R2", 0, w[0], 5, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_perms();
    t_invert();
    t_apply();
    t_wrap();
    t_bad();
    t_ignore();
    t_slots();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule